// File: doc/BRIEF.md
# Doubleword Command Window to Internal Bus Bridge

This block gives software a small window of four 64-bit registers through which it runs single read or write transactions on a 32-bit-addressed internal bus. Software first places write data in the data register if needed. It then writes one command doubleword that carries the direction, the byte count and the bus address. That control write starts the transaction straight away. Software then polls the status register until the done flag appears. A read of status also clears it.

On the bus side the bridge holds a request, with a latched address, byte count, direction and write word, until the bus answers with a one-cycle response. The response carries an error flag and, for reads, a 32-bit data word. A read that fails does not report an error bit. Instead its data field comes back as all ones. A write always reports plain completion, whatever the bus answered.

Register bit positions are given below as ordinary LSB-0 positions of the 64-bit value.

Top module: `cmd_window_bridge`

## Requirements
- R1: The register port accepts an access only when `reg_size_i` is 8 and `reg_addr_i[2:0]` is zero. `reg_addr_i[4:3]` selects the register: 0 is control, 1 is reset, 2 is status and 3 is data. A rejected access changes no state, and if it is a read it returns zero.
- R2: A control write decodes its fields as follows: bit 48 set means read and clear means write, bits 59:56 are the byte count, and bits 31:0 are the bus address. If the command is accepted, `bus_req_o` rises in the next cycle, with the decoded address, count and direction on the bus outputs.
- R3: A control command whose byte count is greater than 8 is dropped. It raises no bus request and leaves the status register unchanged.
- R4: A read that gets an error-free response sets status to bit 11 (done) with the returned word in bits 57:26.
- R5: A read that gets an error response sets status to bit 11 with bits 57:26 all ones.
- R6: A write drives the stored data word on `bus_wdata_o`. When the response arrives, status becomes exactly bit 11, whether or not the bus reported an error.
- R7: A status read returns the current status and clears it to zero in the same access. Control and reset reads return zero.
- R8: A data write stores `reg_wdata_i[63:32]`, and a data read returns that word in bits 63:32 with bits 31:0 zero. Writes to status or reset change nothing.
- R9: `busy_o` and `bus_req_o` stay high from the launch until the cycle in which `bus_resp_i` arrives. Control writes made during that time are ignored. Status takes its new value at the clock edge that samples the response.
- R10: Reset clears the status register, the data register and the busy state.
- R11: Read data appears on `reg_rdata_o` with `reg_rvalid_o` high in the cycle after the read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_valid_i | input | 1 | Register access strobe |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 5 | Byte offset within the window |
| reg_size_i | input | 4 | Access size in bytes |
| reg_wdata_i | input | 64 | Register write value |
| reg_rdata_o | output | 64 | Register read value |
| reg_rvalid_o | output | 1 | Read value valid |
| busy_o | output | 1 | Bus transaction in flight |
| bus_req_o | output | 1 | Bus request, held until response |
| bus_we_o | output | 1 | Bus direction, 1 = write |
| bus_addr_o | output | 32 | Bus address |
| bus_cnt_o | output | 4 | Bus byte count |
| bus_wdata_o | output | 32 | Bus write word |
| bus_resp_i | input | 1 | One-cycle bus response |
| bus_err_i | input | 1 | Response carries an error |
| bus_rdata_i | input | 32 | Response read word |

## Verification
Most faults in the sequencer show up at the bus outputs one cycle after a control write. A direction bit, count or address taken from the wrong slice, or a busy flag that lets a second command through, changes `bus_addr_o`, `bus_we_o` or `bus_req_o` in that cycle. Faults in status formatting or in the clear-on-read rule stay hidden until software reads status. The bench therefore reads status right after each response and reads it a second time to confirm it was cleared. A lost data register value shows up on the next data read and on the write word of the next bus write.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int unsigned REG_W    = 64;
  localparam int unsigned BUS_AW   = 32;
  localparam int unsigned BUS_DW   = 32;
  localparam int unsigned CNT_W    = 4;
  localparam int unsigned MAX_CNT  = 8;
  localparam int unsigned ACC_SIZE = 8;
  // LSB-0 positions of command and status fields
  localparam int unsigned RD_BIT   = 48;
  localparam int unsigned CNT_LSB  = 56;
  localparam int unsigned DONE_BIT = 11;
  localparam int unsigned RD_SHIFT = 26;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_RST  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_DATA = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/bridge_stat.sv
module bridge_stat
  import bridge_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [REG_W-1:0] set_val_i,
  input  logic             clr_i,
  output logic [REG_W-1:0] stat_o
);
  logic [REG_W-1:0] stat_q;

  // a completing transaction outranks a concurrent clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stat_q <= '0;
    else if (set_i)  stat_q <= set_val_i;
    else if (clr_i)  stat_q <= '0;
  end

  assign stat_o = stat_q;

  p_clear_on_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> (stat_o == '0));

  p_hold_when_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(stat_o));
endmodule

// File: rtl/bridge_seq.sv
module bridge_seq
  import bridge_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              cmd_rd_i,
  input  logic [CNT_W-1:0]  cmd_cnt_i,
  input  logic [BUS_AW-1:0] cmd_addr_i,
  input  logic [BUS_DW-1:0] data_word_i,
  output logic              busy_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [BUS_AW-1:0] bus_addr_o,
  output logic [CNT_W-1:0]  bus_cnt_o,
  output logic [BUS_DW-1:0] bus_wdata_o,
  input  logic              bus_resp_i,
  input  logic              bus_err_i,
  input  logic [BUS_DW-1:0] bus_rdata_i,
  output logic              done_o,
  output logic [REG_W-1:0]  done_stat_o
);
  localparam logic [REG_W-1:0] DONE_MASK = REG_W'(1) << DONE_BIT;
  localparam logic [REG_W-1:0] ONES_FLD  = {{(REG_W-BUS_DW){1'b0}}, {BUS_DW{1'b1}}} << RD_SHIFT;

  logic              busy_q;
  logic              we_q;
  logic [BUS_AW-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BUS_DW-1:0] wdata_q;
  logic              cnt_ok;
  logic              start;

  assign cnt_ok = (cmd_cnt_i <= CNT_W'(MAX_CNT));
  assign start  = launch_i && !busy_q && cnt_ok;
  assign done_o = busy_q && bus_resp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      cnt_q   <= '0;
      wdata_q <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      we_q    <= !cmd_rd_i;
      addr_q  <= cmd_addr_i;
      cnt_q   <= cmd_cnt_i;
      wdata_q <= data_word_i;
    end else if (done_o) begin
      busy_q  <= 1'b0;
    end
  end

  always_comb begin
    if (we_q)           done_stat_o = DONE_MASK;
    else if (bus_err_i) done_stat_o = DONE_MASK | ONES_FLD;
    else                done_stat_o = DONE_MASK | ({{(REG_W-BUS_DW){1'b0}}, bus_rdata_i} << RD_SHIFT);
  end

  assign busy_o      = busy_q;
  assign bus_req_o   = busy_q;
  assign bus_we_o    = we_q;
  assign bus_addr_o  = addr_q;
  assign bus_cnt_o   = cnt_q;
  assign bus_wdata_o = wdata_q;

  p_drop_oversize_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_i && !busy_o && (cmd_cnt_i > CNT_W'(MAX_CNT))) |=> !bus_req_o);

  p_launch_fields_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_i && !busy_o && (cmd_cnt_i <= CNT_W'(MAX_CNT))) |=>
      (bus_req_o && bus_addr_o == $past(cmd_addr_i) && bus_we_o == !$past(cmd_rd_i)));

  p_hold_while_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !bus_resp_i) |=> (busy_o && $stable(bus_addr_o) && $stable(bus_we_o)));

  p_release_on_resp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && bus_resp_i) |=> !busy_o);
endmodule

// File: rtl/cmd_window_bridge.sv
module cmd_window_bridge
  import bridge_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_valid_i,
  input  logic              reg_write_i,
  input  logic [4:0]        reg_addr_i,
  input  logic [3:0]        reg_size_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              reg_rvalid_o,
  output logic              busy_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [BUS_AW-1:0] bus_addr_o,
  output logic [CNT_W-1:0]  bus_cnt_o,
  output logic [BUS_DW-1:0] bus_wdata_o,
  input  logic              bus_resp_i,
  input  logic              bus_err_i,
  input  logic [BUS_DW-1:0] bus_rdata_i
);
  reg_sel_e          sel;
  logic              acc_ok;
  logic              wr_ctl, wr_data, rd_stat, rd_any;
  logic [BUS_DW-1:0] data_q;
  logic [REG_W-1:0]  stat;
  logic              done;
  logic [REG_W-1:0]  done_stat;
  logic [REG_W-1:0]  rmux;
  logic [REG_W-1:0]  rdata_q;
  logic              rvalid_q;

  assign sel     = reg_sel_e'(reg_addr_i[4:3]);
  assign acc_ok  = reg_valid_i && (reg_size_i == 4'(ACC_SIZE)) && (reg_addr_i[2:0] == 3'd0);
  assign wr_ctl  = acc_ok && reg_write_i && (sel == SEL_CTL);
  assign wr_data = acc_ok && reg_write_i && (sel == SEL_DATA);
  assign rd_stat = acc_ok && !reg_write_i && (sel == SEL_STAT);
  assign rd_any  = reg_valid_i && !reg_write_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (wr_data) data_q <= reg_wdata_i[REG_W-1:REG_W-BUS_DW];
  end

  bridge_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (wr_ctl),
    .cmd_rd_i    (reg_wdata_i[RD_BIT]),
    .cmd_cnt_i   (reg_wdata_i[CNT_LSB +: CNT_W]),
    .cmd_addr_i  (reg_wdata_i[BUS_AW-1:0]),
    .data_word_i (data_q),
    .busy_o      (busy_o),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_cnt_o   (bus_cnt_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_resp_i  (bus_resp_i),
    .bus_err_i   (bus_err_i),
    .bus_rdata_i (bus_rdata_i),
    .done_o      (done),
    .done_stat_o (done_stat)
  );

  bridge_stat u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (done),
    .set_val_i (done_stat),
    .clr_i     (rd_stat),
    .stat_o    (stat)
  );

  always_comb begin
    rmux = '0;
    if (acc_ok) begin
      unique case (sel)
        SEL_STAT: rmux = stat;
        SEL_DATA: rmux = {data_q, {(REG_W-BUS_DW){1'b0}}};
        default:  rmux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_any;
      if (rd_any) rdata_q <= rmux;
    end
  end

  assign reg_rdata_o  = rdata_q;
  assign reg_rvalid_o = rvalid_q;

  p_done_on_resp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat[DONE_BIT]) |-> $past(bus_resp_i && busy_o));

  p_data_store_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data |=> (data_q == $past(reg_wdata_i[REG_W-1:REG_W-BUS_DW])));

  p_rvalid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_valid_i && !reg_write_i) |=> reg_rvalid_o);

  p_reject_bad_size_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_valid_i && (reg_size_i != 4'(ACC_SIZE)) && !busy_o) |=> !bus_req_o);
endmodule

// File: tb/tb_cmd_window_bridge.sv
module tb_cmd_window_bridge;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_valid_i = 1'b0;
  logic        reg_write_i = 1'b0;
  logic [4:0]  reg_addr_i = '0;
  logic [3:0]  reg_size_i = '0;
  logic [63:0] reg_wdata_i = '0;
  logic [63:0] reg_rdata_o;
  logic        reg_rvalid_o;
  logic        busy_o, bus_req_o, bus_we_o;
  logic [31:0] bus_addr_o, bus_wdata_o;
  logic [3:0]  bus_cnt_o;
  logic        bus_resp_i = 1'b0;
  logic        bus_err_i = 1'b0;
  logic [31:0] bus_rdata_i = '0;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  localparam logic [4:0] A_CTL = 5'h00, A_RST = 5'h08, A_STAT = 5'h10, A_DATA = 5'h18;
  localparam logic [63:0] DONE = 64'h800;

  cmd_window_bridge dut (.*);

  always #2.5 clk_i = ~clk_i;

  function automatic logic [63:0] ctl(input logic rd, input logic [3:0] cnt, input logic [31:0] a);
    return (64'(rd) << 48) | (64'(cnt) << 56) | 64'(a);
  endfunction

  function automatic logic [63:0] rd_stat(input logic [31:0] d);
    return DONE | (64'(d) << 26);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [4:0] a, input logic [3:0] sz, input logic [63:0] d);
    @(posedge clk_i); #1;
    reg_valid_i = 1'b1; reg_write_i = wr; reg_addr_i = a; reg_size_i = sz; reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_valid_i = 1'b0; reg_write_i = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [63:0] d);
    acc(1'b1, a, 4'd8, d);
  endtask

  // driver: pushes expected read value, then issues the read
  task automatic rd(input logic [4:0] a, input logic [3:0] sz, input logic [63:0] exp, input string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    acc(1'b0, a, sz, 64'h0);
  endtask

  task automatic respond(input logic err, input logic [31:0] d);
    @(posedge clk_i); #1;
    bus_resp_i = 1'b1; bus_err_i = err; bus_rdata_i = d;
    @(posedge clk_i); #1;
    bus_resp_i = 1'b0; bus_err_i = 1'b0; bus_rdata_i = '0;
  endtask

  // monitor: compares each read return against the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && reg_rvalid_o) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R11: actual unexpected read %h expected none", reg_rdata_o);
      end else begin
        check(tag_q.pop_front(), reg_rdata_o, exp_q.pop_front());
      end
    end
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10 busy after reset", 64'(busy_o), 64'd0);
    rd(A_STAT, 4'd8, 64'h0, "R10 status reset");
    rd(A_DATA, 4'd8, 64'h0, "R10 data reset");

    // R8 data register store and readback
    wr(A_DATA, 64'hCAFE_F00D_1234_5678);
    rd(A_DATA, 4'd8, 64'hCAFE_F00D_0000_0000, "R8 data readback");
    rd(A_CTL, 4'd8, 64'h0, "R7 control reads zero");
    rd(A_RST, 4'd8, 64'h0, "R7 reset reads zero");

    // R2/R4 successful read
    wr(A_CTL, ctl(1'b1, 4'd4, 32'hD001_0060));
    @(negedge clk_i);
    check("R2 req", 64'(bus_req_o), 64'd1);
    check("R2 addr", 64'(bus_addr_o), 64'hD001_0060);
    check("R2 dir read", 64'(bus_we_o), 64'd0);
    check("R2 count", 64'(bus_cnt_o), 64'd4);
    check("R9 busy", 64'(busy_o), 64'd1);
    // R9 second command ignored while busy
    wr(A_CTL, ctl(1'b0, 4'd1, 32'h1111_2222));
    @(negedge clk_i);
    check("R9 addr held", 64'(bus_addr_o), 64'hD001_0060);
    check("R9 dir held", 64'(bus_we_o), 64'd0);
    rd(A_STAT, 4'd8, 64'h0, "R9 no done before resp");
    respond(1'b0, 32'hA5C3_0F96);
    @(negedge clk_i);
    check("R9 busy drop", 64'(busy_o), 64'd0);
    rd(A_STAT, 4'd8, rd_stat(32'hA5C3_0F96), "R4 read status");
    rd(A_STAT, 4'd8, 64'h0, "R7 cleared");

    // R5 failed read
    wr(A_CTL, ctl(1'b1, 4'd8, 32'h0000_0004));
    respond(1'b1, 32'h1234_5678);
    rd(A_STAT, 4'd8, rd_stat(32'hFFFF_FFFF), "R5 error read");

    // R6 write with error response; also R3 oversize drop keeps status
    wr(A_DATA, 64'h8765_4321_FFFF_FFFF);
    wr(A_CTL, ctl(1'b0, 4'd2, 32'hE001_0000));
    @(negedge clk_i);
    check("R6 wdata", 64'(bus_wdata_o), 64'h8765_4321);
    check("R6 dir write", 64'(bus_we_o), 64'd1);
    respond(1'b1, 32'h0);
    wr(A_CTL, ctl(1'b1, 4'd9, 32'h0000_0100));
    @(negedge clk_i);
    check("R3 no req", 64'(bus_req_o), 64'd0);
    // R8 status/reset writes ignored
    wr(A_STAT, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(A_RST, 64'hFFFF_FFFF_FFFF_FFFF);
    // R1 bad size and misaligned accesses ignored
    rd(A_STAT, 4'd4, 64'h0, "R1 bad size read");
    rd(A_STAT | 5'h4, 4'd8, 64'h0, "R1 misaligned read");
    acc(1'b1, A_DATA, 4'd4, 64'h0);
    acc(1'b1, A_CTL, 4'd4, ctl(1'b1, 4'd1, 32'h5));
    @(negedge clk_i);
    check("R1 bad size ctl", 64'(bus_req_o), 64'd0);
    rd(A_STAT, 4'd8, DONE, "R6 write status");
    rd(A_DATA, 4'd8, 64'h8765_4321_0000_0000, "R1 data kept");

    // R9 response and status read in the same cycle: new status wins
    wr(A_CTL, ctl(1'b1, 4'd1, 32'h40));
    exp_q.push_back(64'h0); tag_q.push_back("R9 same-cycle read");
    @(posedge clk_i); #1;
    reg_valid_i = 1'b1; reg_write_i = 1'b0; reg_addr_i = A_STAT; reg_size_i = 4'd8;
    bus_resp_i = 1'b1; bus_rdata_i = 32'h0000_00FF;
    @(posedge clk_i); #1;
    reg_valid_i = 1'b0; bus_resp_i = 1'b0; bus_rdata_i = '0;
    rd(A_STAT, 4'd8, rd_stat(32'h0000_00FF), "R9 status after race");

    repeat (3) @(posedge clk_i);
    check("R11 scoreboard drained", 64'(exp_q.size()), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule